// File: doc/BRIEF.md
# Core-Side Memory Bus Controller

This controller connects a processor's 32-bit memory bus to a synchronous RAM with four byte lanes. In every cycle it decodes a two-bit cycle code. Bit 1 is the active-low request flag and bit 0 is the sequential flag. Together they separate real memory transfers from internal and coprocessor cycles, which leave the RAM untouched. For each transfer the controller works out which byte lanes the access occupies under the selected byte order. It drives per-lane write enables and copies the write data onto every lane. On reads it brings the addressed byte or half-word down to the low end of the read bus.

A transfer that does not follow on from the previous address pays one setup wait state before the RAM is accessed. A transfer that follows on from the previous address completes in the same cycle. Word and half-word requests that are not aligned to their own size raise an abort flag and leave memory unchanged. A lock input covers an atomic read-then-write pair. The controller shows the bus as held from the locked read until the locked write completes.

Top module: `membus_ctl`

## Requirements
- R1: While reset is held low and after its release, `ready` is 1, and `abort`, `ram_en`, `ram_we`, `bus_locked` and `rdata` are all 0.
- R2: Cycle codes 2'b10 (internal) and 2'b11 (coprocessor) leave `ram_en` and `ram_we` at 0 and `ready` at 1, and `rdata` keeps its last value.
- R3: Cycle code 2'b00 (non-sequential) drives `ready` low for exactly one cycle. The RAM is accessed in the following cycle while the request is held.
- R4: Cycle code 2'b01 (sequential) gives `ready` high and accesses the RAM in the same cycle.
- R5: Size codes are 00 for byte, 01 for half-word and 10 or 11 for word. Under little-endian order (`big_end`=0), the write enables are 4'b0001<<addr[1:0] for a byte, 4'b0011<<addr[1:0] for a half-word and 4'b1111 for a word. `ram_wdata` carries the byte replicated four times or the half-word replicated twice.
- R6: Under big-endian order (`big_end`=1), the lane index is addr[1:0] XOR 3 for bytes and addr[1:0] XOR 2 for half-words. Words use all lanes.
- R7: In the cycle after a read access, `rdata` shows the word. For a byte or half-word it shows the selected lane data zero-extended, with the lane chosen by the rule of R5/R6.
- R8: A half-word with addr[0]=1, or a word with addr[1:0]≠0, raises `abort` and performs no RAM access, so memory is unchanged.
- R9: `bus_locked` rises after a read completes with `lock_in`=1 and stays high while `lock_in` stays high. It falls after the locked write completes.
- R10: `ram_addr` equals addr[AW-1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_code | input | 2 | {no-request, sequential} cycle code |
| acc_size | input | 2 | Access size code |
| wr | input | 1 | 1 = write, 0 = read |
| lock_in | input | 1 | Atomic pair in progress |
| big_end | input | 1 | 1 = big-endian byte order |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data from core |
| ram_rdata | input | 32 | RAM read data (one cycle after access) |
| ready | output | 1 | Low = wait state |
| abort | output | 1 | Misaligned request |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 4 | Per-lane write enables |
| ram_addr | output | AW-2 | RAM word address |
| ram_wdata | output | 32 | Lane-replicated write data |
| rdata | output | 32 | Aligned read data to core |
| bus_locked | output | 1 | Bus held for atomic pair |

## Verification
The hardest case to reach is the locked pair. The lock has to persist across a non-sequential read with its wait state, then an idle gap, then the write, and must clear only when that write completes. The stimulus holds `lock_in` across all three phases and samples `bus_locked` in each one. The big-endian tests write bytes and half-words into one word and then read it back whole and in part. This reveals any lane mirroring mistake that a test writing and reading with the same rule would hide.

// File: rtl/membus_ctl.sv
module membus_ctl #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cyc_code,
  input  logic [1:0]    acc_size,
  input  logic          wr,
  input  logic          lock_in,
  input  logic          big_end,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [31:0]   ram_rdata,
  output logic          ready,
  output logic          abort,
  output logic          ram_en,
  output logic [3:0]    ram_we,
  output logic [AW-3:0] ram_addr,
  output logic [31:0]   ram_wdata,
  output logic [31:0]   rdata,
  output logic          bus_locked
);
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  logic mem, seq, is_byte, is_half, is_word, misal;
  logic waited, rd_pend, lk_q;
  logic [1:0] lane, lane_q, sz_q;
  logic [3:0] lane_mask;
  logic [31:0] fmt, rdata_q;

  assign mem     = !cyc_code[1];
  assign seq     = cyc_code[0];
  assign is_byte = acc_size == SZ_BYTE;
  assign is_half = acc_size == SZ_HALF;
  assign is_word = acc_size[1];
  assign misal   = mem && ((is_half && addr[0]) || (is_word && addr[1:0] != 2'b00));

  assign ready  = !(mem && !seq && !waited);
  assign abort  = misal;
  assign ram_en = mem && ready && !misal;
  assign ram_addr = addr[AW-1:2];

  assign lane = addr[1:0] ^ (big_end ? (is_byte ? 2'd3 : (is_half ? 2'd2 : 2'd0)) : 2'd0);
  assign lane_mask = is_byte ? (4'b0001 << lane) : (is_half ? (4'b0011 << lane) : 4'b1111);
  assign ram_we = (ram_en && wr) ? lane_mask : 4'b0000;
  assign ram_wdata = is_byte ? {4{wdata[7:0]}} : (is_half ? {2{wdata[15:0]}} : wdata);

  always_comb begin
    case (sz_q)
      SZ_BYTE: fmt = {24'b0, ram_rdata[8*lane_q +: 8]};
      SZ_HALF: fmt = {16'b0, ram_rdata[16*lane_q[1] +: 16]};
      default: fmt = ram_rdata;
    endcase
  end

  assign rdata = rd_pend ? fmt : rdata_q;
  assign bus_locked = lk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waited  <= 1'b0;
      rd_pend <= 1'b0;
      lane_q  <= 2'b00;
      sz_q    <= 2'b10;
      rdata_q <= 32'b0;
      lk_q    <= 1'b0;
    end else begin
      waited  <= mem && !seq && !waited;
      rd_pend <= ram_en && !wr;
      if (ram_en) begin
        lane_q <= lane;
        sz_q   <= acc_size;
      end
      rdata_q <= rdata;
      lk_q    <= lock_in && (lk_q || (ram_en && !wr)) && !(lk_q && mem && ready && wr);
    end
  end

  AST_NS_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem && !seq && !ready) |=> ready); // R3
  AST_SEQ_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem && seq) |-> ready); // R4
  AST_ABORT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (ram_we == 4'b0000 && !ram_en)); // R8
  AST_WE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && wr) |-> ($countones(ram_we) == 1 || $countones(ram_we) == 2 || ram_we == 4'hF)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_en && !wr) |=> $stable(rdata)); // R2
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_locked && lock_in && !(mem && ready && wr)) |=> bus_locked); // R9
endmodule

// File: tb/membus_ctl_tb.sv
module membus_ctl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cyc_code = 2'b10;
  logic [1:0] acc_size = 2'b10;
  logic wr = 1'b0, lock_in = 1'b0, big_end = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] ram_rdata;
  logic ready, abort, ram_en, bus_locked;
  logic [3:0] ram_we;
  logic [9:0] ram_addr;
  logic [31:0] ram_wdata, rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int waits;
  logic [3:0] c_we;
  logic c_en, c_ab, c_lock, c_lock_after;
  logic [9:0] c_addr;
  logic [31:0] c_rd;
  logic [31:0] mem [16];

  always #5 clk = ~clk;

  membus_ctl #(.AW(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_code(cyc_code), .acc_size(acc_size), .wr(wr),
    .lock_in(lock_in), .big_end(big_end), .addr(addr), .wdata(wdata),
    .ram_rdata(ram_rdata), .ready(ready), .abort(abort), .ram_en(ram_en),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .rdata(rdata),
    .bus_locked(bus_locked)
  );

  always_ff @(posedge clk) begin
    if (ram_en) begin
      ram_rdata <= mem[ram_addr[3:0]];
      for (int i = 0; i < 4; i++)
        if (ram_we[i]) mem[ram_addr[3:0]][8*i +: 8] <= ram_wdata[8*i +: 8];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [1:0] code, input logic [1:0] sz, input logic w,
                           input logic be, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cyc_code = code; acc_size = sz; wr = w; big_end = be; addr = a; wdata = d;
    waits = 0;
    #1;
    while (!ready && waits < 5) begin
      waits++;
      @(negedge clk);
      #1;
    end
    c_we = ram_we; c_en = ram_en; c_ab = abort; c_addr = ram_addr; c_lock = bus_locked;
    @(negedge clk);
    cyc_code = 2'b10; wr = 1'b0;
    #1;
    c_rd = rdata; c_lock_after = bus_locked;
  endtask

  task automatic t_reset();
    check("R1 ready", {31'b0, ready}, 32'd1);
    check("R1 abort", {31'b0, abort}, 32'd0);
    check("R1 ram_en", {31'b0, ram_en}, 32'd0);
    check("R1 we", {28'b0, ram_we}, 32'd0);
    check("R1 locked", {31'b0, bus_locked}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
  endtask

  task automatic t_word_ns_seq();
    bus_cycle(2'b00, 2'b10, 1'b1, 1'b0, 12'h010, 32'hDEADBEEF);
    check("R3 one wait", waits, 32'd1);
    check("R5 word we", {28'b0, c_we}, 32'hF);
    check("R10 ram_addr", {22'b0, c_addr}, 32'h4);
    bus_cycle(2'b01, 2'b10, 1'b0, 1'b0, 12'h010, 32'h0);
    check("R4 no wait", waits, 32'd0);
    check("R4 access", {31'b0, c_en}, 32'd1);
    check("R7 word read", c_rd, 32'hDEADBEEF);
  endtask

  task automatic t_le_bytes();
    for (int i = 0; i < 4; i++) begin
      bus_cycle(2'b01, 2'b00, 1'b1, 1'b0, 12'h020 + 12'(i), {24'h0, 8'h11 * 8'(i + 1)});
      check("R5 byte we", {28'b0, c_we}, 32'(4'b0001 << i));
    end
    bus_cycle(2'b01, 2'b01, 1'b1, 1'b0, 12'h026, 32'h0000_5566);
    check("R5 half we", {28'b0, c_we}, 32'hC);
    bus_cycle(2'b01, 2'b10, 1'b0, 1'b0, 12'h020, 32'h0);
    check("R5 LE word", c_rd, 32'h44332211);
    bus_cycle(2'b01, 2'b00, 1'b0, 1'b0, 12'h022, 32'h0);
    check("R7 LE byte read", c_rd, 32'h33);
    bus_cycle(2'b01, 2'b01, 1'b0, 1'b0, 12'h026, 32'h0);
    check("R7 LE half read", c_rd, 32'h5566);
  endtask

  task automatic t_be();
    bus_cycle(2'b01, 2'b00, 1'b1, 1'b1, 12'h031, 32'h0000_00AA);
    check("R6 BE byte we", {28'b0, c_we}, 32'h4);
    bus_cycle(2'b01, 2'b01, 1'b1, 1'b1, 12'h032, 32'h0000_BBCC);
    check("R6 BE half we", {28'b0, c_we}, 32'h3);
    bus_cycle(2'b01, 2'b10, 1'b0, 1'b1, 12'h030, 32'h0);
    check("R6 BE word", c_rd, 32'h00AABBCC);
    bus_cycle(2'b01, 2'b00, 1'b0, 1'b1, 12'h031, 32'h0);
    check("R7 BE byte read", c_rd, 32'hAA);
    bus_cycle(2'b01, 2'b01, 1'b0, 1'b1, 12'h032, 32'h0);
    check("R7 BE half read", c_rd, 32'hBBCC);
  endtask

  task automatic t_misalign();
    bus_cycle(2'b01, 2'b01, 1'b1, 1'b0, 12'h041, 32'hFFFF);
    check("R8 half abort", {31'b0, c_ab}, 32'd1);
    check("R8 half no we", {28'b0, c_we}, 32'd0);
    bus_cycle(2'b00, 2'b10, 1'b1, 1'b0, 12'h042, 32'hFFFF_FFFF);
    check("R8 word abort", {31'b0, c_ab}, 32'd1);
    check("R8 word no access", {31'b0, c_en}, 32'd0);
    bus_cycle(2'b01, 2'b10, 1'b0, 1'b0, 12'h040, 32'h0);
    check("R8 memory unchanged", c_rd, 32'h0);
  endtask

  task automatic t_idle();
    bus_cycle(2'b01, 2'b10, 1'b0, 1'b0, 12'h010, 32'h0);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cyc_code = k[0] ? 2'b11 : 2'b10; wr = 1'b1; acc_size = 2'b10; addr = 12'h010; wdata = 32'h1234_5678;
      #1;
      check("R2 no ram_en", {31'b0, ram_en}, 32'd0);
      check("R2 ready", {31'b0, ready}, 32'd1);
      check("R2 rdata held", rdata, 32'hDEADBEEF);
    end
    wr = 1'b0;
    bus_cycle(2'b01, 2'b10, 1'b0, 1'b0, 12'h010, 32'h0);
    check("R2 memory untouched", c_rd, 32'hDEADBEEF);
  endtask

  task automatic t_lock();
    lock_in = 1'b1;
    bus_cycle(2'b00, 2'b10, 1'b0, 1'b0, 12'h050, 32'h0);
    check("R9 locked after read", {31'b0, c_lock_after}, 32'd1);
    @(negedge clk); #1;
    check("R9 held while idle", {31'b0, bus_locked}, 32'd1);
    bus_cycle(2'b00, 2'b10, 1'b1, 1'b0, 12'h050, 32'h0000_0077);
    check("R9 locked during write", {31'b0, c_lock}, 32'd1);
    check("R9 released after write", {31'b0, c_lock_after}, 32'd0);
    lock_in = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    ram_rdata = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_word_ns_seq();
    t_le_bytes();
    t_be();
    t_misalign();
    t_idle();
    t_lock();
    finish_run();
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule